// File: doc/BRIEF.md
# Per-Pixel Control Buffer with Result-Indexed Update Table

This block keeps a small 8-bit control value for every pixel. Typical uses are flags, coverage counters and masks. Pixels arrive as addresses only. The block takes no surface data. Each stored value is compared against an internal operand register, and the pass/fail bit is placed on the block's own line of a shared result bus. The block then reads the whole result bus and uses it as an index into a small condition table. The word it selects holds two things: a write-enable bit, and a 3-bit op-code that says how to change the stored value.

The update is therefore chosen per pixel by the combination of test outcomes across all buffers. It is not one fixed operation. A counter that goes up when a neighbour's test passes and down when it fails, for example, needs only two kinds of table entry. A host port loads the table, the operand and the test mode. The pipeline accepts a new pixel every cycle. Results of a pixel still in flight are forwarded to a later pixel at the same address.

Top module: `ctlbuf_top`

## Requirements
- R1: After synchronous reset, every stored value is 0, every table word is 0 (disabled, op 0), the operand is 0 and the test mode is equals; `upd_valid`, `upd_we` and `res_own` are 0.
- R2: A pixel sampled with `pix_valid` high at a rising edge shows on the `upd_*` outputs after the third rising edge counting that one; outputs are idle before that.
- R3: The test result on `res_own` is 1 when stored value == operand (mode 0) or stored value != 0 (mode 1), and `res_own` is 0 whenever `upd_valid` is 0.
- R4: The table index equals `res_bus_in` with bit `OWN_IDX` (default 0) replaced by the block's own test result; the incoming value of that bit is ignored.
- R5: A table word is {bit 3 = enable, bits 2:0 = op}; with enable 0 the pixel is not written, `upd_we` is 0 and `upd_new` equals `upd_old`.
- R6: Op-codes: 0 keep, 1 increment, 2 decrement, 3 load operand, 4 clear, 5 invert bit 0, 6 AND operand, 7 OR operand; `upd_new` is the value written at the next edge.
- R7: Increment of 255 gives 255 and decrement of 0 gives 0.
- R8: Pixels to the same address on consecutive cycles each see the value left by the previous one.
- R9: Host writes on `cfg_we`: `cfg_sel` 0 writes table word `cfg_addr` from `cfg_data[3:0]`, 1 writes the operand from `cfg_data`, 2 writes the test mode from `cfg_data[0]`, 3 changes nothing.
- R10: A table holding increment where index bit 1 is set and decrement where it is clear makes the stored value count the passes and fails of the external line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_addr | input | RB_W | Table word index for table writes |
| cfg_data | input | 8 | Configuration write data |
| pix_valid | input | 1 | Pixel address valid |
| pix_addr | input | PIX_W | Pixel address |
| res_bus_in | input | RB_W | Full result bus as seen by this buffer |
| res_own | output | 1 | This buffer's test result line |
| upd_valid | output | 1 | Pixel in the update stage |
| upd_addr | output | PIX_W | Address of that pixel |
| upd_old | output | 8 | Value before update |
| upd_new | output | 8 | Value after update |
| upd_we | output | 1 | Pixel is written |

## Verification
The assertions check the following on every cycle: the three-cycle latency, that the own line is quiet when the update stage is empty, that a disabled word leaves the value alone, that increment and decrement never wrap, and that each write lands in storage. They also check that a pixel directly behind a write to the same address starts from the value just written. Only the bench's scenarios can show that the table index is built correctly from the external lines and the own bit, and that each op-code computes the right value against the operand. The same holds for the counter idiom over a run of pixels and for the ignored configuration select.

// File: rtl/ctlbuf_pkg.sv
package ctlbuf_pkg;
    localparam int VAL_W = 8;
    typedef logic [VAL_W-1:0] val_t;

    typedef enum logic [2:0] {
        OP_KEEP = 3'd0,
        OP_INC  = 3'd1,
        OP_DEC  = 3'd2,
        OP_LOAD = 3'd3,
        OP_CLR  = 3'd4,
        OP_FLIP = 3'd5,
        OP_AND  = 3'd6,
        OP_OR   = 3'd7
    } upd_op_e;

    typedef enum logic {
        TST_EQ = 1'b0,
        TST_NZ = 1'b1
    } tst_mode_e;

    typedef enum logic [1:0] {
        CFG_TABLE = 2'd0,
        CFG_OPND  = 2'd1,
        CFG_MODE  = 2'd2,
        CFG_NONE  = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic    en;
        upd_op_e op;
    } cond_word_t;

    function automatic val_t apply_op(upd_op_e op, val_t cur, val_t opnd);
        val_t r;
        case (op)
            OP_INC:  r = (cur == '1) ? cur : cur + 1'b1;
            OP_DEC:  r = (cur == '0) ? cur : cur - 1'b1;
            OP_LOAD: r = opnd;
            OP_CLR:  r = '0;
            OP_FLIP: r = cur ^ val_t'(1);
            OP_AND:  r = cur & opnd;
            OP_OR:   r = cur | opnd;
            default: r = cur;
        endcase
        return r;
    endfunction

    function automatic logic eval_test(tst_mode_e m, val_t cur, val_t opnd);
        return (m == TST_NZ) ? (cur != '0) : (cur == opnd);
    endfunction
endpackage

// File: rtl/ctlbuf_cfg.sv
module ctlbuf_cfg
    import ctlbuf_pkg::*;
#(
    parameter int RB_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [RB_W-1:0]      cfg_addr,
    input  logic [VAL_W-1:0]     cfg_data,
    input  logic [RB_W-1:0]      idx_i,
    output cond_word_t           word_o,
    output val_t                 opnd_o,
    output tst_mode_e            mode_o
);
    localparam int TBL_DEPTH = 1 << RB_W;

    cond_word_t tbl [TBL_DEPTH];
    val_t       opnd_q;
    tst_mode_e  mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TBL_DEPTH; i++) tbl[i] <= '0;
            opnd_q <= '0;
            mode_q <= TST_EQ;
        end else if (cfg_we) begin
            case (cfg_sel_e'(cfg_sel))
                CFG_TABLE: tbl[cfg_addr] <= cond_word_t'(cfg_data[3:0]);
                CFG_OPND:  opnd_q <= cfg_data;
                CFG_MODE:  mode_q <= tst_mode_e'(cfg_data[0]);
                default:   ;
            endcase
        end
    end

    assign word_o = tbl[idx_i];
    assign opnd_o = opnd_q;
    assign mode_o = mode_q;

    // R9: operand write takes effect at the next cycle
    assert_opnd_load_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == CFG_OPND) |=> (opnd_o == $past(cfg_data)));
endmodule

// File: rtl/ctlbuf_mem.sv
module ctlbuf_mem
    import ctlbuf_pkg::*;
#(
    parameter int PIX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] rd_addr,
    output val_t             rd_data,
    input  logic             wr_en,
    input  logic [PIX_W-1:0] wr_addr,
    input  val_t             wr_data
);
    localparam int DEPTH = 1 << PIX_W;

    val_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store[rd_addr];

    // R6: a write lands in storage
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (store[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/ctlbuf_update.sv
module ctlbuf_update
    import ctlbuf_pkg::*;
#(
    parameter int RB_W    = 3,
    parameter int OWN_IDX = 0
) (
    input  logic [RB_W-1:0] bus_i,
    input  logic            own_i,
    output logic [RB_W-1:0] idx_o,
    input  cond_word_t      word_i,
    input  val_t            cur_i,
    input  val_t            opnd_i,
    output val_t            new_o,
    output logic            we_o
);
    localparam logic [RB_W-1:0] OWN_MASK = RB_W'(1) << OWN_IDX;

    always_comb begin
        idx_o = (bus_i & ~OWN_MASK) | (own_i ? OWN_MASK : '0);
        we_o  = word_i.en;
        new_o = word_i.en ? apply_op(word_i.op, cur_i, opnd_i) : cur_i;
    end
endmodule

// File: rtl/ctlbuf_top.sv
module ctlbuf_top
    import ctlbuf_pkg::*;
#(
    parameter int RB_W    = 3,
    parameter int OWN_IDX = 0,
    parameter int PIX_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [RB_W-1:0]  cfg_addr,
    input  logic [7:0]       cfg_data,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_addr,
    input  logic [RB_W-1:0]  res_bus_in,
    output logic             res_own,
    output logic             upd_valid,
    output logic [PIX_W-1:0] upd_addr,
    output logic [7:0]       upd_old,
    output logic [7:0]       upd_new,
    output logic             upd_we
);
    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] addr;
    } st_addr_t;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] addr;
        val_t             val;
    } st_read_t;

    typedef struct packed {
        logic             vld;
        logic [PIX_W-1:0] addr;
        val_t             val;
        logic             res;
    } st_test_t;

    st_addr_t   s1;
    st_read_t   s2;
    st_test_t   s3;

    val_t       mem_rd, rd_fwd, s2_fwd, new_val, opnd;
    logic       do_wr, wr_en;
    cond_word_t word;
    tst_mode_e  mode;
    logic [RB_W-1:0] tbl_idx;

    ctlbuf_cfg #(.RB_W(RB_W)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .idx_i(tbl_idx),
        .word_o(word), .opnd_o(opnd), .mode_o(mode)
    );

    ctlbuf_mem #(.PIX_W(PIX_W)) u_mem (
        .clk(clk), .rst(rst), .rd_addr(s1.addr), .rd_data(mem_rd),
        .wr_en(wr_en), .wr_addr(s3.addr), .wr_data(new_val)
    );

    ctlbuf_update #(.RB_W(RB_W), .OWN_IDX(OWN_IDX)) u_upd (
        .bus_i(res_bus_in), .own_i(s3.res), .idx_o(tbl_idx),
        .word_i(word), .cur_i(s3.val), .opnd_i(opnd),
        .new_o(new_val), .we_o(do_wr)
    );

    assign wr_en = s3.vld && do_wr;

    // forward the value being written to younger pixels at the same address
    always_comb begin
        rd_fwd = (wr_en && s3.addr == s1.addr) ? new_val : mem_rd;
        s2_fwd = (wr_en && s3.addr == s2.addr) ? new_val : s2.val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= '{vld: pix_valid, addr: pix_addr};
            s2 <= '{vld: s1.vld, addr: s1.addr, val: rd_fwd};
            s3 <= '{vld: s2.vld, addr: s2.addr, val: s2_fwd,
                    res: s2.vld & eval_test(mode, s2_fwd, opnd)};
        end
    end

    assign res_own   = s3.res;
    assign upd_valid = s3.vld;
    assign upd_addr  = s3.addr;
    assign upd_old   = s3.val;
    assign upd_new   = new_val;
    assign upd_we    = wr_en;

    // R2: three-cycle latency from pixel acceptance to update stage
    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> $past(pix_valid, 3));

    // R3: own result line is quiet when no pixel is being updated
    assert_quiet_line_R3: assert property (@(posedge clk) disable iff (rst)
        res_own |-> upd_valid);

    // R5: a pixel that is not written keeps its value
    assert_no_write_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && !upd_we) |-> (upd_new == upd_old));

    // R7: increment and decrement never wrap
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_we && word.op == OP_INC) |-> (upd_new >= upd_old));
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
        (upd_we && word.op == OP_DEC) |-> (upd_new <= upd_old));

    // R8: a pixel right behind a write to its address starts from that write
    assert_forward_R8: assert property (@(posedge clk) disable iff (rst)
        (upd_valid && $past(upd_we) && $past(upd_addr) == upd_addr)
            |-> (upd_old == $past(upd_new)));
endmodule

// File: tb/sim_ctlbuf_top.sv
module sim_ctlbuf_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic [2:0] cfg_addr;
    logic [7:0] cfg_data;
    logic       pix_valid;
    logic [3:0] pix_addr;
    logic [2:0] res_bus_in;
    logic       res_own, upd_valid, upd_we;
    logic [3:0] upd_addr;
    logic [7:0] upd_old, upd_new;

    int checks = 0;
    int errors = 0;

    int mmem [16];
    int t_en [8];
    int t_op [8];
    int m_opnd;
    int m_mode;
    int pa [64];
    int pe [64];

    always #10 clk = ~clk;

    ctlbuf_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .pix_valid(pix_valid),
        .pix_addr(pix_addr), .res_bus_in(res_bus_in), .res_own(res_own),
        .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_old(upd_old),
        .upd_new(upd_new), .upd_we(upd_we)
    );

    function automatic int mop(int op, int cur, int o);
        case (op)
            1: return (cur == 255) ? 255 : cur + 1;
            2: return (cur == 0) ? 0 : cur - 1;
            3: return o;
            4: return 0;
            5: return cur ^ 1;
            6: return cur & o;
            7: return cur | o;
            default: return cur;
        endcase
    endfunction

    task automatic chk(string tag, int got, int exp, string what);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic cfg(int sel, int a, int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = 3'(a); cfg_data = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            0: begin t_en[a] = (d >> 3) & 1; t_op[a] = d & 7; end
            1: m_opnd = d & 255;
            2: m_mode = d & 1;
            default: ;
        endcase
    endtask

    task automatic fill_table(int en, int op);
        for (int i = 0; i < 8; i++) cfg(0, i, (en << 3) | op);
    endtask

    task automatic check_px(int j, string tag);
        int a, old, t, idx, en, nv;
        if (pa[j] < 0) begin
            checks++;
            if (upd_valid !== 1'b0 || res_own !== 1'b0) begin
                errors++;
                $display("FAIL %s idle slot %0d: actual valid=%0b res=%0b expected 0 0",
                         tag, j, upd_valid, res_own);
            end
            return;
        end
        a   = pa[j];
        old = mmem[a];
        t   = m_mode ? (old != 0) : (old == m_opnd);
        idx = (pe[j] & 6) | t;
        en  = t_en[idx];
        nv  = en ? mop(t_op[idx], old, m_opnd) : old;
        checks++;
        if (upd_valid !== 1'b1 || int'(upd_addr) != a || int'(upd_old) != old ||
            int'(upd_new) != nv || int'(upd_we) != en || int'(res_own) != t) begin
            errors++;
            $display("FAIL %s pixel %0d: actual v=%0b a=%0d old=%0d new=%0d we=%0b res=%0b expected v=1 a=%0d old=%0d new=%0d we=%0d res=%0d",
                     tag, j, upd_valid, upd_addr, upd_old, upd_new, upd_we, res_own,
                     a, old, nv, en, t);
        end
        mmem[a] = nv;
    endtask

    task automatic run(int n, string tag);
        for (int i = 0; i < n + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                res_bus_in = 3'(pe[i-3]);
                #1;
                check_px(i - 3, tag);
            end
            if (i < n && pa[i] >= 0) begin
                pix_valid = 1'b1; pix_addr = 4'(pa[i]);
            end else begin
                pix_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_sel = '0; cfg_addr = '0; cfg_data = '0;
        pix_valid = 1'b0; pix_addr = '0; res_bus_in = '0;
        for (int i = 0; i < 16; i++) mmem[i] = 0;
        for (int i = 0; i < 8; i++) begin t_en[i] = 0; t_op[i] = 0; end
        m_opnd = 0; m_mode = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle outputs and cleared state after reset
        chk("R1", int'(upd_valid), 0, "upd_valid");
        chk("R1", int'(res_own), 0, "res_own");
        chk("R1", int'(upd_we), 0, "upd_we");
        for (int i = 0; i < 16; i++) begin pa[i] = i; pe[i] = i % 8; end
        run(16, "R1");

        // R2: exact latency of a single pixel
        @(negedge clk);
        pix_valid = 1'b1; pix_addr = 4'd5; res_bus_in = '0;
        @(negedge clk);
        pix_valid = 1'b0;
        chk("R2", int'(upd_valid), 0, "valid after edge 1");
        @(negedge clk);
        chk("R2", int'(upd_valid), 0, "valid after edge 2");
        @(negedge clk);
        chk("R2", int'(upd_valid), 1, "valid after edge 3");
        chk("R2", int'(upd_addr), 5, "addr after edge 3");
        @(negedge clk);
        chk("R2", int'(upd_valid), 0, "valid after edge 4");

        // R6 R3 R5: sweep over op-codes, operands, test modes and bus patterns
        for (int k = 0; k < 8; k++) begin
            for (int md = 0; md < 2; md++) begin
                cfg(1, 0, (k * 53 + 17 + md * 90) & 255);
                cfg(2, 0, md);
                for (int i = 0; i < 8; i++)
                    cfg(0, i, ((((i + k) % 7) != 0 ? 1 : 0) << 3) | ((i + k) % 8));
                for (int i = 0; i < 20; i++) begin
                    if (i % 9 == 8)              pa[i] = -1;
                    else if (i % 4 == 1 && pa[i-1] >= 0) pa[i] = pa[i-1];
                    else                         pa[i] = (i * 3 + k) % 16;
                    pe[i] = (i * 5 + k + md) % 8;
                end
                run(20, "R6 R3 R5");
            end
        end

        // R7: saturation at both ends
        cfg(1, 0, 255);
        fill_table(1, 3);
        for (int i = 0; i < 4; i++) begin pa[i] = 2; pe[i] = i; end
        run(4, "R7");
        fill_table(1, 1);
        for (int i = 0; i < 4; i++) begin pa[i] = 2; pe[i] = 7 - i; end
        run(4, "R7");
        chk("R7", mmem[2], 255, "model after increments");
        fill_table(1, 4);
        run(2, "R7");
        fill_table(1, 2);
        run(4, "R7");

        // R4: own bit of the bus is replaced by the test result
        cfg(2, 0, 1);
        for (int i = 0; i < 8; i++) cfg(0, i, ((i & 1) << 3) | 1);
        for (int i = 0; i < 12; i++) begin pa[i] = i % 3; pe[i] = (i & 1) ? 7 : 0; end
        run(12, "R4");

        // R10: count passes and fails of external line 1
        for (int i = 0; i < 8; i++) cfg(0, i, (1 << 3) | (((i >> 1) & 1) ? 1 : 2));
        for (int i = 0; i < 14; i++) begin pa[i] = 7; pe[i] = (i % 3 == 2) ? 0 : 2; end
        run(14, "R10");

        // R9: select 3 changes nothing
        cfg(3, 5, 8'hFF);
        for (int i = 0; i < 8; i++) begin pa[i] = (i * 5) % 16; pe[i] = i; end
        run(8, "R9");

        // R8: back-to-back pixels to one address
        fill_table(1, 1);
        for (int i = 0; i < 10; i++) begin pa[i] = 9; pe[i] = i % 8; end
        run(10, "R8");
        fill_table(1, 5);
        for (int i = 0; i < 6; i++) begin pa[i] = 9; pe[i] = 0; end
        run(6, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule